// File: doc/BRIEF.md
# Decimal and binary add/subtract core

This block is the arithmetic heart of an accumulator machine's add-with-carry and subtract-with-borrow operations. It takes an accumulator word, an operand, a carry input and three mode selects. It returns the sum or difference together with carry, overflow, negative and zero flags. Operand width is chosen at run time: either the low byte or the whole 16-bit word.

In binary mode the result is a plain sum with carry. In decimal mode the operands are treated as packed BCD. The arithmetic walks upward from the least significant digit, and each digit's correction is settled before its carry moves to the next digit. Subtraction reuses the same adder: the operand is complemented, and a digit whose position gave no carry has 6 taken away at that position.

Overflow is read from the sign bit before the top digit is corrected. After that the top digit is adjusted. A parameter selects a registered output, so the result can appear one clock after the inputs, or it can be taken combinationally.

Top module: `bcd_addsub`

## Requirements
- R1: With dec_i=0 and sub_i=0, the active-width result equals acc_i + opnd_i + carry_i modulo 2^w, where w is 16 when wide_i=1 and 8 when wide_i=0. carry_o is bit w of that sum.
- R2: With dec_i=1 and sub_i=0, valid packed-BCD inputs give the BCD sum. Each digit whose sum exceeds 9 is corrected by adding 6 before its carry feeds the next digit. carry_o=1 when the decimal sum exceeds the active width (e.g. 8-bit 0x58+0x46+1 gives 0x05 with carry 1).
- R3: With dec_i=1 and sub_i=1, carry_i acts as not-borrow and valid BCD inputs give the BCD difference. carry_o=1 means no borrow (e.g. 8-bit 0x00-0x01 with carry_i=1 gives 0x99 with carry 0).
- R4: With dec_i=0 and sub_i=1, the result is acc_i - opnd_i - (1 - carry_i) modulo 2^w, and carry_o=1 exactly when no borrow occurs.
- R5: ovf_o = NOT(a[s] XOR b[s]) AND (a[s] XOR p[s]), where s is bit 15 (16-bit) or bit 7 (8-bit), b is the operand after inversion for subtraction, and p is the sum before the top digit's decimal correction.
- R6: In decimal mode, overflow reflects the uncorrected top digit (8-bit 0x50+0x50 gives result 0x00, carry 1, overflow 1).
- R7: neg_o is the top bit of the active-width result, and zero_o is 1 exactly when the active-width result is all zeros, regardless of the upper byte in 8-bit mode.
- R8: In 16-bit decimal mode all four digits carry through the chain (0x9999+0x0001 gives 0x0000 with carry 1; 0x1000-0x0001 with carry_i=1 gives 0x0999 with carry 1).
- R9: Non-decimal digit values (A to F) are not rejected and follow the same correction rules (8-bit decimal 0x0F+0x00 gives 0x15).
- R10: With wide_i=0, res_o[15:8] equals acc_i[15:8], and opnd_i[15:8] has no effect on any output.
- R11: With OUT_REG=1, outputs update on the rising clock edge after the inputs are presented, and rst_ni=0 forces res_o and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register and checks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_i | input | 16 | Accumulator value |
| opnd_i | input | 16 | Operand value |
| carry_i | input | 1 | Carry in (not-borrow for subtraction) |
| dec_i | input | 1 | 1 = packed BCD arithmetic, 0 = binary |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| res_o | output | 16 | Result word |
| carry_o | output | 1 | Carry out / not-borrow |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Top bit of the active result |
| zero_o | output | 1 | Active result is zero |

## Verification
The per-digit check assumes that both acc_i and opnd_i hold only digits 0 to 9 over the full word. Under that condition every corrected lower digit must stay decimal, in both add and subtract. The bench's invalid-digit and upper-byte pass-through cases deliberately fall outside that condition, and the check does not apply to them. The registered-output checks assume that inputs are held stable across each rising edge. The bench keeps to this by changing inputs only on the falling edge.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
   localparam int DIG_W = 4;

   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } adsu_flags_t;
endpackage

// File: rtl/bcd_addsub_digit.sv
// One decimal digit position of the carry chain.
module bcd_addsub_digit
   import bcd_addsub_pkg::*;
#(
   parameter int W = 16,
   parameter int K = 0,
   localparam int RW = W + 2,
   localparam int SH = K * DIG_W
) (
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   input  logic          c_i,
   input  logic [RW-1:0] prev_i,
   input  logic          sub_i,
   output logic [RW-1:0] raw_o,
   output logic [RW-1:0] corr_o,
   output logic          c_o
);
   localparam logic [RW-1:0] FIELD = RW'(4'hF) << SH;
   localparam logic [RW-1:0] LOW   = (RW'(1) << SH) - RW'(1);
   localparam logic [RW-1:0] DMAX  = (RW'(1) << (SH + DIG_W)) - RW'(1);
   localparam logic [RW-1:0] THR   = (RW'(10) << SH) - RW'(1);
   localparam logic [RW-1:0] SIX   = RW'(6) << SH;

   logic [RW-1:0] adj;

   always_comb begin
      raw_o = ({2'b00, a_i} & FIELD) + ({2'b00, b_i} & FIELD)
            + (RW'(c_i) << SH) + (prev_i & LOW);
      adj   = raw_o + ((raw_o > THR) ? SIX : '0);
      if (sub_i) begin
         c_o    = raw_o > DMAX;
         corr_o = c_o ? raw_o : raw_o - SIX;
      end else begin
         c_o    = adj > DMAX;
         corr_o = adj;
      end
   end
endmodule

// File: rtl/bcd_addsub_final.sv
// Selects binary or decimal pre-sum, derives overflow, corrects top digit, forms flags.
module bcd_addsub_final
   import bcd_addsub_pkg::*;
#(
   parameter int W = 16,
   localparam int RW = W + 2,
   localparam int HW = W / 2
) (
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   input  logic          c_i,
   input  logic          dec_i,
   input  logic          sub_i,
   input  logic          wide_i,
   input  logic [RW-1:0] raw_n_i,
   input  logic [RW-1:0] raw_w_i,
   output logic [W-1:0]  res_o,
   output adsu_flags_t   flags_o
);
   localparam logic [RW-1:0] MASK_W = (RW'(1) << W) - RW'(1);
   localparam logic [RW-1:0] MASK_N = (RW'(1) << HW) - RW'(1);
   localparam logic [RW-1:0] THR_W  = (RW'(10) << (W - DIG_W)) - RW'(1);
   localparam logic [RW-1:0] THR_N  = (RW'(10) << (HW - DIG_W)) - RW'(1);
   localparam logic [RW-1:0] SIX_W  = RW'(6) << (W - DIG_W);
   localparam logic [RW-1:0] SIX_N  = RW'(6) << (HW - DIG_W);

   logic [RW-1:0] bin_w, bin_n, pre, fin, mask, thr, six;
   logic          sa, sb, sp;

   always_comb begin
      bin_w = {2'b00, a_i} + {2'b00, b_i} + RW'(c_i);
      bin_n = RW'(a_i[HW-1:0]) + RW'(b_i[HW-1:0]) + RW'(c_i);
      if (dec_i) pre = wide_i ? raw_w_i : raw_n_i;
      else       pre = wide_i ? bin_w : bin_n;
      mask = wide_i ? MASK_W : MASK_N;
      thr  = wide_i ? THR_W  : THR_N;
      six  = wide_i ? SIX_W  : SIX_N;
      sa   = wide_i ? a_i[W-1] : a_i[HW-1];
      sb   = wide_i ? b_i[W-1] : b_i[HW-1];
      sp   = wide_i ? pre[W-1] : pre[HW-1];
      flags_o.v = ~(sa ^ sb) & (sa ^ sp);
      if (!dec_i)     fin = pre;
      else if (!sub_i) fin = (pre > thr) ? pre + six : pre;
      else            fin = (pre > mask) ? pre : pre - six;
      flags_o.c = (dec_i && sub_i) ? (pre > mask) : (fin > mask);
      if (wide_i) begin
         res_o     = fin[W-1:0];
         flags_o.n = fin[W-1];
         flags_o.z = (fin[W-1:0] == '0);
      end else begin
         res_o     = {a_i[W-1:HW], fin[HW-1:0]};
         flags_o.n = fin[HW-1];
         flags_o.z = (fin[HW-1:0] == '0);
      end
   end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
   import bcd_addsub_pkg::*;
#(
   parameter int NDIG = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int W  = NDIG * DIG_W,
   localparam int HW = W / 2,
   localparam int RW = W + 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] opnd_i,
   input  logic         carry_i,
   input  logic         dec_i,
   input  logic         wide_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         carry_o,
   output logic         ovf_o,
   output logic         neg_o,
   output logic         zero_o
);
   if (NDIG < 2 || (NDIG % 2) != 0) begin : g_bad_ndig
      $error("bcd_addsub: NDIG must be even and at least 2");
   end

   logic [W-1:0]  b_eff;
   logic [RW-1:0] run [NDIG+1];
   logic [RW-1:0] raw [NDIG];
   logic          cy  [NDIG+1];
   logic [W-1:0]  res_c;
   adsu_flags_t   flg_c;

   assign b_eff  = sub_i ? ~opnd_i : opnd_i;
   assign run[0] = '0;
   assign cy[0]  = carry_i;

   for (genvar k = 0; k < NDIG; k++) begin : g_dig
      bcd_addsub_digit #(.W(W), .K(k)) u_dig (
         .a_i   (acc_i),
         .b_i   (b_eff),
         .c_i   (cy[k]),
         .prev_i(run[k]),
         .sub_i (sub_i),
         .raw_o (raw[k]),
         .corr_o(run[k+1]),
         .c_o   (cy[k+1])
      );
   end

   bcd_addsub_final #(.W(W)) u_fin (
      .a_i    (acc_i),
      .b_i    (b_eff),
      .c_i    (carry_i),
      .dec_i  (dec_i),
      .sub_i  (sub_i),
      .wide_i (wide_i),
      .raw_n_i(raw[NDIG/2-1]),
      .raw_w_i(raw[NDIG-1]),
      .res_o  (res_c),
      .flags_o(flg_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            res_o   <= '0;
            carry_o <= 1'b0;
            ovf_o   <= 1'b0;
            neg_o   <= 1'b0;
            zero_o  <= 1'b0;
         end else begin
            res_o   <= res_c;
            carry_o <= flg_c.c;
            ovf_o   <= flg_c.v;
            neg_o   <= flg_c.n;
            zero_o  <= flg_c.z;
         end
      end
   end else begin : g_comb
      assign res_o   = res_c;
      assign carry_o = flg_c.c;
      assign ovf_o   = flg_c.v;
      assign neg_o   = flg_c.n;
      assign zero_o  = flg_c.z;
   end

   // ---------------- checks ----------------
   function automatic logic all_dec(input logic [W-1:0] v);
      logic ok = 1'b1;
      for (int i = 0; i < NDIG; i++) if (v[i*DIG_W +: DIG_W] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   // R2 / R3: every corrected lower digit stays decimal for decimal inputs
   for (genvar k = 0; k < NDIG - 1; k++) begin : g_chk
      a_r2_digit_bcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (dec_i && all_dec(acc_i) && all_dec(opnd_i)) |->
            (run[k+1][k*DIG_W +: DIG_W] <= 4'd9));
   end

   // R7: a zero result never reports negative
   a_r7_zero_not_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_o |-> !neg_o);

   if (OUT_REG) begin : g_chk_reg
      a_r4_bin_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!dec_i && sub_i && wide_i) |=>
            (res_o == $past(acc_i - opnd_i - W'(!carry_i))));
      a_r5_bin_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!dec_i && !sub_i && wide_i && (acc_i[W-1] == opnd_i[W-1])) |=>
            (ovf_o == (res_o[W-1] != $past(acc_i[W-1]))));
      a_r10_upper_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wide_i |=> (res_o[W-1:HW] == $past(acc_i[W-1:HW])));
   end else begin : g_chk_comb
      a_r4_bin_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!dec_i && sub_i && wide_i) |->
            (res_o == acc_i - opnd_i - W'(!carry_i)));
      a_r5_bin_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!dec_i && !sub_i && wide_i && (acc_i[W-1] == opnd_i[W-1])) |->
            (ovf_o == (res_o[W-1] != acc_i[W-1])));
      a_r10_upper_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wide_i |-> (res_o[W-1:HW] == acc_i[W-1:HW]));
   end
endmodule

// File: tb/tb_bcd_addsub.sv
module tb_bcd_addsub;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] acc = 16'h1234, opnd = 16'h4321;
   logic        cin = 1'b1, dec = 1'b1, wide = 1'b1, sub = 1'b0;
   logic [15:0] res;
   logic        c_o, v_o, n_o, z_o;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_addsub dut (
      .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .opnd_i(opnd), .carry_i(cin),
      .dec_i(dec), .wide_i(wide), .sub_i(sub), .res_o(res), .carry_o(c_o),
      .ovf_o(v_o), .neg_o(n_o), .zero_o(z_o)
   );

   // flags compared as {carry, overflow, negative, zero}
   task automatic check(input string req, input logic [15:0] er, input logic [3:0] ef);
      n_chk++;
      if (res !== er || {c_o, v_o, n_o, z_o} !== ef) begin
         n_fail++;
         $display("FAIL %s: res=%h cvnz=%b expected res=%h cvnz=%b",
                  req, res, {c_o, v_o, n_o, z_o}, er, ef);
      end
   endtask

   task automatic drive(input logic [15:0] a, b, input logic c, d, w, s);
      @(negedge clk);
      acc = a; opnd = b; cin = c; dec = d; wide = w; sub = s;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R11 reset", 16'h0000, 4'b0000);
      rst_n = 1'b1;
   endtask

   task automatic t_bin_add;
      drive(16'hFFFF, 16'h0001, 0, 0, 1, 0); check("R1 16-bit wrap", 16'h0000, 4'b1001);
      drive(16'h007F, 16'h0001, 0, 0, 0, 0); check("R1 8-bit", 16'h0080, 4'b0110);
   endtask

   task automatic t_bin_sub;
      drive(16'h0000, 16'h0001, 1, 0, 0, 1); check("R4 8-bit borrow", 16'h00FF, 4'b0010);
      drive(16'h8000, 16'h0001, 1, 0, 1, 1); check("R4 16-bit", 16'h7FFF, 4'b1100);
   endtask

   task automatic t_dec_add;
      drive(16'h0012, 16'h0034, 0, 1, 0, 0); check("R2 no carry", 16'h0046, 4'b0000);
      drive(16'h0058, 16'h0046, 1, 1, 0, 0); check("R2 carry in/out", 16'h0005, 4'b1100);
      drive(16'h0099, 16'h0001, 0, 1, 0, 0); check("R2 ripple", 16'h0000, 4'b1001);
   endtask

   task automatic t_dec_sub;
      drive(16'h0050, 16'h0025, 1, 1, 0, 1); check("R3 no borrow", 16'h0025, 4'b1000);
      drive(16'h0050, 16'h0025, 0, 1, 0, 1); check("R3 borrow in", 16'h0024, 4'b1000);
      drive(16'h0000, 16'h0001, 1, 1, 0, 1); check("R3 borrow out", 16'h0099, 4'b0010);
   endtask

   task automatic t_overflow;
      drive(16'h0050, 16'h0050, 0, 1, 0, 0); check("R6 R5 pre-correction", 16'h0000, 4'b1101);
   endtask

   task automatic t_wide_dec;
      drive(16'h9999, 16'h0001, 0, 1, 1, 0); check("R8 add ripple", 16'h0000, 4'b1001);
      drive(16'h1234, 16'h5678, 0, 1, 1, 0); check("R8 add", 16'h6912, 4'b0000);
      drive(16'h1000, 16'h0001, 1, 1, 1, 1); check("R8 sub", 16'h0999, 4'b1000);
   endtask

   task automatic t_invalid;
      drive(16'h000F, 16'h0000, 0, 1, 0, 0); check("R9 digit F", 16'h0015, 4'b0000);
   endtask

   task automatic t_narrow;
      drive(16'hAB12, 16'hFF34, 0, 1, 0, 0); check("R10 dec upper", 16'hAB46, 4'b0000);
      drive(16'hCD05, 16'h7703, 1, 0, 0, 1); check("R10 bin sub upper", 16'hCD02, 4'b1000);
      drive(16'h5599, 16'h0001, 0, 1, 0, 0); check("R7 zero low byte", 16'h5500, 4'b1001);
   endtask

   task automatic t_latency;
      drive(16'h0012, 16'h0034, 0, 1, 0, 0);
      @(negedge clk);
      acc = 16'h0099; opnd = 16'h0001;
      #(CLK_PERIOD/2 - 1);
      check("R11 held before edge", 16'h0046, 4'b0000);
      @(posedge clk);
      #1;
      check("R11 after edge", 16'h0000, 4'b1001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_bin_add();
      t_bin_sub();
      t_dec_add();
      t_dec_sub();
      t_overflow();
      t_wide_dec();
      t_invalid();
      t_narrow();
      t_latency();
      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule